// File: doc/BRIEF.md
# Power-Up DAC Restore Sequencer

This block runs once after reset, which stands for power-up, and restores the two 8-bit DAC codes from word 0 of the nonvolatile array. At power-up the part is in power-down with writes disabled. The sequencer then waits for chip select to go low for the first time. When it does, the sequencer requests a read of word 0. It places the upper byte in the channel 0 code register and the lower byte in the channel 1 code register, and pulses both load strobes. It then counts a settle interval and signals the mode logic to leave power-down.

For the whole of that first chip-select low period, the serial front end is held off. The sequencer presents a deselected chip select to the decoder, forces the clock and data lines to zero, and keeps the data-out enable low. Serial traffic in that period therefore never reaches the instruction decoder. The front end is released at the first cycle in which chip select is high after the restore has finished. A done flag stays high until the next reset, and later chip-select low periods never start another restore.

Top module: `autoload_seq`

## Requirements
- R1: In reset and right after it, busy, done, both load strobes, mode_release and mem_rd_req are 0. The front end is blocked: fe_cs_n is 1, and fe_sck, fe_sdi and fe_sdo_oe are 0.
- R2: While cs_n stays high after reset, no read is requested and busy stays 0.
- R3: The cycle after cs_n is first sampled low, mem_rd_req rises with mem_rd_addr equal to 0, and busy rises. The request is held until a cycle in which mem_rd_valid is 1.
- R4: The cycle after the one in which mem_rd_req and mem_rd_valid are both 1, dac0_load and dac1_load are 1 for exactly one cycle. At that point dac0_code holds bits [15:8] of mem_rd_data and dac1_code holds bits [7:0].
- R5: done and mode_release rise SETTLE_CYCLES+1 cycles after the load strobe. mode_release is a one-cycle pulse, and busy falls in that same cycle.
- R6: Once set, done stays 1 until reset. A later falling edge of cs_n requests no read and produces no load strobe.
- R7: Until done is 1 and cs_n has been sampled high, the front end stays blocked as in R1, whatever sck, sdi and dec_sdo_oe do.
- R8: After release, fe_cs_n follows cs_n, fe_sck follows sck, fe_sdi follows sdi and fe_sdo_oe follows dec_sdo_oe.
- R9: If cs_n rises before the restore ends, the restore still completes. The front end is then released one cycle after done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| cs_n | input | 1 | Chip select from pad, active low, synchronous |
| sck | input | 1 | Serial clock from pad |
| sdi | input | 1 | Serial data in from pad |
| dec_sdo_oe | input | 1 | Data-out enable requested by the decoder |
| fe_cs_n | output | 1 | Gated chip select to decoder |
| fe_sck | output | 1 | Gated serial clock to decoder |
| fe_sdi | output | 1 | Gated serial data to decoder |
| fe_sdo_oe | output | 1 | Gated data-out enable to pad |
| mem_rd_req | output | 1 | Read request to array |
| mem_rd_addr | output | ADDR_W | Read address, always word 0 |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | DATA_W | Read data word |
| dac0_code | output | DATA_W/2 | Channel 0 code |
| dac1_code | output | DATA_W/2 | Channel 1 code |
| dac0_load | output | 1 | Channel 0 load strobe |
| dac1_load | output | 1 | Channel 1 load strobe |
| mode_release | output | 1 | Pulse: leave initial power-down |
| busy | output | 1 | Restore in progress |
| done | output | 1 | Restore complete, sticky until reset |

## Verification
The bench sets SETTLE_CYCLES to 20 instead of the default, which corresponds to about 2 ms at 100 MHz. This keeps the exact done-timing check to a few dozen cycles. DATA_W stays 16 and ADDR_W is 7. The bench runs two memory latencies, 3 cycles and 0 cycles. With these values it can cover a restore where chip select stays low past the end and one where it rises early. It can also repeat a chip-select low after completion, all within one short run.

// File: rtl/autoload_seq.sv
module autoload_seq #(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 7,
  parameter int SETTLE_CYCLES = 200000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                sdi,
  input  logic                dec_sdo_oe,
  output logic                fe_cs_n,
  output logic                fe_sck,
  output logic                fe_sdi,
  output logic                fe_sdo_oe,
  output logic                mem_rd_req,
  output logic [ADDR_W-1:0]   mem_rd_addr,
  input  logic                mem_rd_valid,
  input  logic [DATA_W-1:0]   mem_rd_data,
  output logic [DATA_W/2-1:0] dac0_code,
  output logic [DATA_W/2-1:0] dac1_code,
  output logic                dac0_load,
  output logic                dac1_load,
  output logic                mode_release,
  output logic                busy,
  output logic                done
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int CNT_W  = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  typedef enum logic [2:0] {
    S_WAIT, S_REQ, S_LOAD, S_SETTLE, S_HOLD, S_FREE
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_WAIT;
      cnt          <= '0;
      dac0_code    <= '0;
      dac1_code    <= '0;
      done         <= 1'b0;
      mode_release <= 1'b0;
    end else begin
      mode_release <= 1'b0;
      unique case (state)
        S_WAIT:   if (!cs_n) state <= S_REQ;
        S_REQ:    if (mem_rd_valid) begin
                    dac0_code <= mem_rd_data[DATA_W-1:BYTE_W];
                    dac1_code <= mem_rd_data[BYTE_W-1:0];
                    state     <= S_LOAD;
                  end
        S_LOAD:   begin
                    cnt   <= '0;
                    state <= S_SETTLE;
                  end
        S_SETTLE: if (cnt == CNT_LAST) begin
                    done         <= 1'b1;
                    mode_release <= 1'b1;
                    state        <= S_HOLD;
                  end else begin
                    cnt <= cnt + 1'b1;
                  end
        S_HOLD:   if (cs_n) state <= S_FREE;
        S_FREE:   state <= S_FREE;
        default:  state <= S_WAIT;
      endcase
    end
  end

  assign pass        = (state == S_FREE);
  assign busy        = (state == S_REQ) || (state == S_LOAD) || (state == S_SETTLE);
  assign mem_rd_req  = (state == S_REQ);
  assign mem_rd_addr = '0;
  assign dac0_load   = (state == S_LOAD);
  assign dac1_load   = (state == S_LOAD);

  assign fe_cs_n   = cs_n | ~pass;
  assign fe_sck    = sck & pass;
  assign fe_sdi    = sdi & pass;
  assign fe_sdo_oe = dec_sdo_oe & pass;
endmodule

module autoload_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fe_cs_n,
  input logic                fe_sck,
  input logic                fe_sdi,
  input logic                fe_sdo_oe,
  input logic                mem_rd_req,
  input logic                mem_rd_valid,
  input logic [DATA_W/2-1:0] dac0_code,
  input logic                dac0_load,
  input logic                dac1_load,
  input logic                mode_release,
  input logic                busy,
  input logic                done
);
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req);
  a_r4_load_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && mem_rd_valid |=> dac0_load && dac1_load);
  a_r4_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_rd_valid) |=> $stable(dac0_code));
  a_r5_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> mode_release && !busy);
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r6_no_second_load: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !dac0_load && !dac1_load && !mem_rd_req);
  a_r7_front_end_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> fe_cs_n && !fe_sck && !fe_sdi && !fe_sdo_oe);
endmodule

bind autoload_seq autoload_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fe_cs_n(fe_cs_n), .fe_sck(fe_sck), .fe_sdi(fe_sdi),
  .fe_sdo_oe(fe_sdo_oe), .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid),
  .dac0_code(dac0_code), .dac0_load(dac0_load), .dac1_load(dac1_load),
  .mode_release(mode_release), .busy(busy), .done(done));

// File: tb/autoload_seq_test.sv
module autoload_seq_test;
  localparam int DW = 16;
  localparam int AW = 7;
  localparam int SC = 20;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sck = 0, sdi = 0, dec_sdo_oe = 0;
  logic mem_rd_valid = 0;
  logic [DW-1:0] mem_rd_data = '0;
  logic fe_cs_n, fe_sck, fe_sdi, fe_sdo_oe, mem_rd_req;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0] dac0_code, dac1_code;
  logic dac0_load, dac1_load, mode_release, busy, done;

  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  autoload_seq #(.DATA_W(DW), .ADDR_W(AW), .SETTLE_CYCLES(SC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .dec_sdo_oe(dec_sdo_oe), .fe_cs_n(fe_cs_n), .fe_sck(fe_sck), .fe_sdi(fe_sdi),
    .fe_sdo_oe(fe_sdo_oe), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .dac0_code(dac0_code), .dac1_code(dac1_code), .dac0_load(dac0_load),
    .dac1_load(dac1_load), .mode_release(mode_release), .busy(busy), .done(done));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [3:0] fe_vec();
    return {fe_cs_n, fe_sck, fe_sdi, fe_sdo_oe};
  endfunction

  task automatic do_reset();
    rst_n = 0; cs_n = 1; sck = 0; sdi = 0; dec_sdo_oe = 0; mem_rd_valid = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "busy/done/loads/release/req", {busy, done, dac0_load, dac1_load, mode_release, mem_rd_req}, 0);
    sck = 1; sdi = 1; dec_sdo_oe = 1;
    #1;
    chk("R1", "front end blocked", fe_vec(), 4'b1000);
    sck = 0; sdi = 0; dec_sdo_oe = 0;
  endtask

  task automatic t_idle_high();
    for (int i = 0; i < 8; i++) begin
      sck = i[0]; sdi = i[1];
      tick();
      chk("R2", "no request while cs high", {mem_rd_req, busy}, 0);
      chk("R7", "blocked before restore", fe_vec(), 4'b1000);
    end
    sck = 0; sdi = 0;
  endtask

  task automatic t_restore(input logic [15:0] word, input int lat, input bit early);
    cs_n = 0;
    tick();
    chk("R3", "req after first cs low", {mem_rd_req, busy}, 2'b11);
    chk("R3", "address word 0", mem_rd_addr, 0);
    sck = 1; sdi = 1; dec_sdo_oe = 1;
    #1;
    chk("R7", "traffic discarded in window", fe_vec(), 4'b1000);
    if (early) cs_n = 1;
    for (int i = 0; i < lat; i++) begin
      sck = ~sck;
      tick();
      chk("R3", "request held", mem_rd_req, 1);
      chk("R7", "blocked while waiting", fe_vec(), 4'b1000);
    end
    mem_rd_valid = 1; mem_rd_data = word;
    tick();
    mem_rd_valid = 0; mem_rd_data = 16'hDEAD;
    chk("R4", "both load strobes", {dac0_load, dac1_load}, 2'b11);
    chk("R4", "ch0 upper byte", dac0_code, word[15:8]);
    chk("R4", "ch1 lower byte", dac1_code, word[7:0]);
    for (int i = 0; i < SC; i++) begin
      tick();
      if (i == 0) chk("R4", "strobe single cycle", {dac0_load, dac1_load}, 0);
      chk("R5", "done not yet", {done, mode_release}, 0);
      chk("R7", "blocked while settling", fe_vec(), 4'b1000);
    end
    tick();
    chk("R5", "done and release", {done, mode_release, busy}, 3'b110);
    chk("R4", "codes kept", {dac0_code, dac1_code}, word);
    tick();
    chk("R5", "release is a pulse", mode_release, 0);
    if (early) begin
      chk("R9", "released after early cs rise", fe_vec(), 4'b1111);
    end else begin
      chk("R7", "still blocked in first cs low", fe_vec(), 4'b1000);
      cs_n = 1;
      tick();
    end
    sck = 0; sdi = 1; dec_sdo_oe = 0;
    #1;
    chk("R8", "pass-through A", fe_vec(), 4'b1010);
    cs_n = 0; sck = 1; sdi = 0; dec_sdo_oe = 1;
    #1;
    chk("R8", "pass-through B", fe_vec(), 4'b0101);
  endtask

  task automatic t_no_rerun();
    for (int i = 0; i < 6; i++) begin
      cs_n = i[0];
      tick();
      chk("R6", "no second read", {mem_rd_req, dac0_load, dac1_load, busy}, 0);
      chk("R6", "done sticky", done, 1);
    end
    cs_n = 1;
  endtask

  initial begin
    t_reset_state();
    t_idle_high();
    t_restore(16'hA53C, 3, 0);
    t_no_rerun();
    t_reset_state();
    chk("R6", "done cleared by reset", done, 0);
    t_restore(16'h00FF, 0, 1);
    t_no_rerun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule